// File: doc/BRIEF.md
# Two-Stage Oscillator Trim Search

This block tunes a trimmable oscillator until its measured frequency count is as close as a simple search can get it to a target. The oscillator has two trim codes: a coarse divider code and a fine calibration code. The block owns both codes. For each trial it raises a request to an external frequency meter, waits for the meter's done pulse and reads back the count.

The search first walks the coarse code one step at a time toward the target. It stops when two trials in a row land on opposite sides of the target, and it keeps whichever of the two is nearer. It then walks the fine code the same way, starting from the kept point. A second crossing ends the search. The chosen setting is then measured once more, and that final count is reported.

A count of zero, or a code that would leave its range, aborts the search with a failure. The target is given in MHz and turned into a count using a 26 MHz reference and a 1024-cycle gate.

Top module: `osc_trim_search`

## Requirements
- R1: After reset the block is idle. `meas_req_o`, `busy_o`, `done_o` and `fail_o` are low, `count_o` is 0, and both trim codes sit at their midpoint 2^(W-1), which is 32 for the 6-bit defaults.
- R2: A `start_i` pulse while idle or finished latches the target count round(mhz × 1024 / 26), with halves rounded up. It sets both codes to their midpoint, selects the coarse stage and raises `busy_o` on the next clock edge.
- R3: After each trial, the code being searched moves by +1 when the count is below the target, by −1 when it is above, and by 0 when the two are equal.
- R4: When the sign of (target − count) differs between the previous and current trials, the block keeps the trial with the smaller absolute error, and keeps the current trial on a tie. The first trial of a search makes no such comparison.
- R5: The first such crossing switches the search from the coarse code to the fine code, starting from the kept point. The second crossing ends the search.
- R6: If a step would take the searched code below 0, or to 2^W or above, the search ends with `done_o` and `fail_o` high and `count_o` at 0.
- R7: A measured count of 0 ends the search at once with `done_o` and `fail_o` high and no further measurement.
- R8: After a successful search, the kept codes are driven, one more measurement is made, and its count appears on `count_o` with `done_o` high and `fail_o` low. Each search therefore makes one request per trial plus one.
- R9: `meas_req_o` stays high from its rise until `meas_done_i` is seen. The trim codes change only while `meas_req_o` is low.
- R10: `start_i` has no effect while `busy_o` is high.
- R11: `done_o`, `fail_o`, `count_o` and the codes hold their final values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new search |
| target_mhz_i | input | MHZ_W | Target frequency in MHz, sampled at start |
| meas_req_o | output | 1 | Measurement request, held until done |
| meas_done_i | input | 1 | One-cycle pulse from the meter, count valid |
| meas_cnt_i | input | CNT_W | Measured count |
| coarse_o | output | COARSE_W | Coarse divider trim code |
| fine_o | output | FINE_W | Fine calibration trim code |
| count_o | output | CNT_W | Final measured count |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished |
| fail_o | output | 1 | Search finished with failure |

## Verification
The assertions assume the meter follows a level-request protocol. It pulses `meas_done_i` for a single cycle only while `meas_req_o` is high, and it never answers a request twice. The bench meter model arms on a low request and counts a fixed latency after the rise. It then returns a count computed from the codes currently driven, and it ignores the request until that request has dropped. Each meter profile is a deterministic function of the two codes. The profiles are chosen so that no trial hits the target exactly twice in a row, so every search either crosses the target or runs out of range.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS,
    ST_EVAL,
    ST_FMEAS,
    ST_DONE
  } trim_state_e;

  typedef enum logic {
    STG_COARSE,
    STG_FINE
  } trim_stage_e;
endpackage

// File: rtl/osc_trim_target.sv
module osc_trim_target #(
  parameter int MHZ_W   = 8,
  parameter int CNT_W   = 16,
  parameter int SCALE   = 1024,
  parameter int REF_DIV = 26
) (
  input  logic [MHZ_W-1:0] mhz_i,
  output logic [CNT_W-1:0] tgt_o
);
  localparam int PW = MHZ_W + $clog2(SCALE) + 2;

  logic [PW-1:0] num;

  // round half up
  assign num   = PW'(mhz_i) * PW'(SCALE) + PW'(REF_DIV / 2);
  assign tgt_o = CNT_W'(num / PW'(REF_DIV));
endmodule

// File: rtl/osc_trim_err.sv
module osc_trim_err #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]  tgt_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic signed [1:0] sgn_o,
  output logic [CNT_W:0]    mag_o
);
  logic [CNT_W:0] diff;

  assign diff  = {1'b0, tgt_i} - {1'b0, cnt_i};
  assign mag_o = diff[CNT_W] ? (~diff + 1'b1) : diff;
  assign sgn_o = (diff == '0) ? 2'sb00 : (diff[CNT_W] ? 2'sb11 : 2'sb01);
endmodule

// File: rtl/osc_trim_step.sv
module osc_trim_step #(
  parameter int W = 6
) (
  input  logic [W-1:0]      code_i,
  input  logic signed [1:0] dir_i,
  output logic [W-1:0]      code_o,
  output logic              oor_o
);
  logic [W+1:0] sum;

  assign sum    = {2'b00, code_i} + {{W{dir_i[1]}}, dir_i};
  assign code_o = sum[W-1:0];
  // negative, or reached 2^W
  assign oor_o  = sum[W+1] | sum[W];
endmodule

// File: rtl/osc_trim_search.sv
module osc_trim_search
  import osc_trim_pkg::*;
#(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 6,
  parameter int CNT_W    = 16,
  parameter int MHZ_W    = 8,
  parameter int SCALE    = 1024,
  parameter int REF_DIV  = 26
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MHZ_W-1:0]    target_mhz_i,
  output logic                meas_req_o,
  input  logic                meas_done_i,
  input  logic [CNT_W-1:0]    meas_cnt_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o
);
  localparam logic [COARSE_W-1:0] C_MID = {1'b1, {(COARSE_W-1){1'b0}}};
  localparam logic [FINE_W-1:0]   F_MID = {1'b1, {(FINE_W-1){1'b0}}};

  trim_state_e         state_q;
  trim_stage_e         stage_q, stage_nx;
  logic [CNT_W-1:0]    tgt_q, tgt_new, cnt_q, prev_cnt_q, count_q;
  logic [COARSE_W-1:0] coarse_q, prev_coarse_q;
  logic [FINE_W-1:0]   fine_q, prev_fine_q;
  logic                prev_vld_q, fail_q;

  logic signed [1:0]   cur_sgn, prev_sgn, keep_sgn;
  logic [CNT_W:0]      cur_mag, prev_mag;
  logic                bracket, keep_prev;
  logic [COARSE_W-1:0] keep_c, c_nx;
  logic [FINE_W-1:0]   keep_f, f_nx;
  logic [CNT_W-1:0]    keep_cnt;
  logic                c_oor, f_oor;

  osc_trim_target #(
    .MHZ_W(MHZ_W), .CNT_W(CNT_W), .SCALE(SCALE), .REF_DIV(REF_DIV)
  ) u_tgt (
    .mhz_i (target_mhz_i),
    .tgt_o (tgt_new)
  );

  osc_trim_err #(.CNT_W(CNT_W)) u_err_cur (
    .tgt_i (tgt_q), .cnt_i (cnt_q), .sgn_o (cur_sgn), .mag_o (cur_mag)
  );

  osc_trim_err #(.CNT_W(CNT_W)) u_err_prev (
    .tgt_i (tgt_q), .cnt_i (prev_cnt_q), .sgn_o (prev_sgn), .mag_o (prev_mag)
  );

  assign bracket   = prev_vld_q && (cur_sgn != prev_sgn);
  assign keep_prev = bracket && (prev_mag < cur_mag);
  assign keep_c    = keep_prev ? prev_coarse_q : coarse_q;
  assign keep_f    = keep_prev ? prev_fine_q   : fine_q;
  assign keep_cnt  = keep_prev ? prev_cnt_q    : cnt_q;
  assign keep_sgn  = keep_prev ? prev_sgn      : cur_sgn;
  assign stage_nx  = bracket ? STG_FINE : stage_q;

  osc_trim_step #(.W(COARSE_W)) u_step_c (
    .code_i (keep_c), .dir_i (keep_sgn), .code_o (c_nx), .oor_o (c_oor)
  );

  osc_trim_step #(.W(FINE_W)) u_step_f (
    .code_i (keep_f), .dir_i (keep_sgn), .code_o (f_nx), .oor_o (f_oor)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      stage_q       <= STG_COARSE;
      tgt_q         <= '0;
      cnt_q         <= '0;
      prev_cnt_q    <= '0;
      count_q       <= '0;
      coarse_q      <= C_MID;
      fine_q        <= F_MID;
      prev_coarse_q <= C_MID;
      prev_fine_q   <= F_MID;
      prev_vld_q    <= 1'b0;
      fail_q        <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q    <= ST_MEAS;
            stage_q    <= STG_COARSE;
            tgt_q      <= tgt_new;
            coarse_q   <= C_MID;
            fine_q     <= F_MID;
            prev_vld_q <= 1'b0;
            fail_q     <= 1'b0;
            count_q    <= '0;
          end
        end
        ST_MEAS: begin
          if (meas_done_i) begin
            cnt_q   <= meas_cnt_i;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (cnt_q == '0) begin
            fail_q  <= 1'b1;
            state_q <= ST_DONE;
          end else if (bracket && stage_q == STG_FINE) begin
            coarse_q <= keep_c;
            fine_q   <= keep_f;
            state_q  <= ST_FMEAS;
          end else begin
            stage_q       <= stage_nx;
            prev_vld_q    <= 1'b1;
            prev_coarse_q <= keep_c;
            prev_fine_q   <= keep_f;
            prev_cnt_q    <= keep_cnt;
            if ((stage_nx == STG_COARSE) ? c_oor : f_oor) begin
              fail_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              coarse_q <= (stage_nx == STG_COARSE) ? c_nx : keep_c;
              fine_q   <= (stage_nx == STG_COARSE) ? keep_f : f_nx;
              state_q  <= ST_MEAS;
            end
          end
        end
        ST_FMEAS: begin
          if (meas_done_i) begin
            count_q <= meas_cnt_i;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign meas_req_o = (state_q == ST_MEAS) || (state_q == ST_FMEAS);
  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o     = (state_q == ST_DONE);
  assign fail_o     = fail_q;
  assign coarse_o   = coarse_q;
  assign fine_o     = fine_q;
  assign count_o    = count_q;
endmodule

// File: rtl/osc_trim_search_chk.sv
module osc_trim_search_chk #(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                meas_req_o,
  input logic                meas_done_i,
  input logic [COARSE_W-1:0] coarse_o,
  input logic [FINE_W-1:0]   fine_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                fail_o
);
  localparam logic [COARSE_W-1:0] C_MID = {1'b1, {(COARSE_W-1){1'b0}}};
  localparam logic [FINE_W-1:0]   F_MID = {1'b1, {(FINE_W-1){1'b0}}};

  // R9
  codes_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_req_o && $past(meas_req_o)) |-> ($stable(coarse_o) && $stable(fine_o)));

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_req_o && !meas_done_i) |=> meas_req_o);

  // R2
  start_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (coarse_o == C_MID && fine_o == F_MID));

  // R6
  fail_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !meas_req_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !meas_req_o);
endmodule

bind osc_trim_search osc_trim_search_chk #(
  .COARSE_W(COARSE_W), .FINE_W(FINE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .meas_req_o  (meas_req_o),
  .meas_done_i (meas_done_i),
  .coarse_o    (coarse_o),
  .fine_o      (fine_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/osc_trim_search_tb.sv
module osc_trim_search_tb;
  localparam int CW = 6;
  localparam int FW = 6;
  localparam int NW = 16;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] mhz = '0;
  logic          req;
  logic          mdone = 1'b0;
  logic [NW-1:0] mcnt = '0;
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;
  logic [NW-1:0] count;
  logic          busy, done, fail;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  int trials = 0;
  int cyc = 0;
  int code_viol = 0;

  int e_c, e_f, e_cnt, e_fail, e_trials;

  always #2.5 clk = ~clk;

  osc_trim_search u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .target_mhz_i (mhz),
    .meas_req_o (req), .meas_done_i (mdone), .meas_cnt_i (mcnt),
    .coarse_o (coarse), .fine_o (fine), .count_o (count),
    .busy_o (busy), .done_o (done), .fail_o (fail)
  );

  function automatic int model(int md, int c, int f);
    case (md)
      0: return 2000 + c * 50 + f * 4;
      1: return 0;
      2: return 100 + c * 2 + f;
      3: return 1000 + c * 100 + f;
      default: return 3000 + c * 60 + f * 5;
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  // meter: fixed latency, arms on a low request
  logic armed = 1'b1;
  int   dly = 0;
  always @(negedge clk) begin
    mdone <= 1'b0;
    if (dly != 0) begin
      if (dly == 1) begin
        mdone <= 1'b1;
        mcnt  <= NW'(model(mode, int'(coarse), int'(fine)));
      end
      dly <= dly - 1;
    end else if (req && armed) begin
      armed <= 1'b0;
      dly   <= 3;
    end
    if (!req) armed <= 1'b1;
  end

  logic          req_d = 1'b0;
  logic [CW-1:0] c_d = '0;
  logic [FW-1:0] f_d = '0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (req && !req_d) trials <= trials + 1;
    if (req && req_d && (coarse != c_d || fine != f_d)) code_viol <= code_viol + 1;
    req_d <= req;
    c_d   <= coarse;
    f_d   <= fine;
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // reference search taken from the requirements
  task automatic expect_search(input int md, input int mh);
    int t, cd, fi, c, s, pc, ps, pcd, pfi, pv, stg;
    t = (mh * 1024 + 13) / 26;
    cd = 1 << (CW - 1); fi = 1 << (FW - 1);
    pv = 0; stg = 0; pc = 0; ps = 0; pcd = 0; pfi = 0;
    e_trials = 0; e_fail = 0; e_cnt = 0;
    for (int it = 0; it < 1000; it++) begin
      c = model(md, cd, fi);
      e_trials++;
      if (c == 0) begin e_fail = 1; break; end
      s = sgn(t - c);
      if (pv != 0 && s != ps) begin
        if (absv(t - pc) < absv(t - c)) begin
          cd = pcd; fi = pfi; c = pc; s = ps;
        end
        if (stg == 1) break;
        stg = 1;
      end
      pv = 1; pc = c; ps = s; pcd = cd; pfi = fi;
      if (stg == 0) begin
        cd = cd + s;
        if (cd < 0 || cd >= (1 << CW)) begin e_fail = 1; break; end
      end else begin
        fi = fi + s;
        if (fi < 0 || fi >= (1 << FW)) begin e_fail = 1; break; end
      end
    end
    e_c = cd; e_f = fi;
    if (e_fail == 0) begin
      e_trials++;
      e_cnt = model(md, cd, fi);
    end
  endtask

  task automatic launch(input int md, input int mh);
    mode = md;
    expect_search(md, mh);
    @(negedge clk);
    trials = 0;
    start = 1'b1;
    mhz = MW'(mh);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string rq);
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk({rq, " search completes"}, int'(done), 1);
  endtask

  task automatic t_reset();
    chk("R1 req", int'(req), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 count", int'(count), 0);
    chk("R1 coarse", int'(coarse), 32);
    chk("R1 fine", int'(fine), 32);
  endtask

  task automatic t_ascend();
    launch(0, 100);
    chk("R2 busy after start", int'(busy), 1);
    chk("R2 coarse mid", int'(coarse), 32);
    chk("R2 fine mid", int'(fine), 32);
    repeat (10) @(negedge clk);
    // R10: start with another target while busy
    start = 1'b1;
    mhz = 8'd200;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    chk("R10 coarse unchanged by busy start", int'(coarse), e_c);
    chk("R3 ascend coarse", int'(coarse), 36);
    chk("R4 tie keeps current fine", int'(fine), 35);
    chk("R8 count", int'(count), e_cnt);
    chk("R8 count value", int'(count), 3940);
    chk("R8 fail low", int'(fail), 0);
    chk("R5 trial count", trials, e_trials);
    repeat (6) @(negedge clk);
    chk("R11 done held", int'(done), 1);
    chk("R11 count held", int'(count), e_cnt);
    chk("R11 fine held", int'(fine), e_f);
  endtask

  task automatic t_descend();
    launch(4, 100);
    wait_done("R3");
    chk("R3 descend coarse", int'(coarse), e_c);
    chk("R4 keep closer prev fine", int'(fine), e_f);
    chk("R4 fine value", int'(fine), 32);
    chk("R8 descend count", int'(count), e_cnt);
    chk("R5 descend trials", trials, e_trials);
    chk("R8 descend fail", int'(fail), 0);
  endtask

  task automatic t_zero();
    launch(1, 100);
    wait_done("R7");
    chk("R7 fail", int'(fail), 1);
    chk("R7 single trial", trials, 1);
    chk("R7 count", int'(count), 0);
  endtask

  task automatic t_coarse_oor();
    launch(2, 100);
    wait_done("R6");
    chk("R6 coarse overflow fail", int'(fail), 1);
    chk("R6 coarse trials", trials, e_trials);
    chk("R6 count zero", int'(count), 0);
  endtask

  task automatic t_fine_oor();
    launch(3, 50);
    wait_done("R6");
    chk("R6 fine overflow fail", int'(fail), e_fail);
    chk("R5 fine stage trials", trials, e_trials);
    chk("R5 kept coarse", int'(coarse), 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ascend();
    t_descend();
    t_zero();
    t_coarse_oor();
    t_fine_oor();
    chk("R9 codes stable while requesting", code_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule